// File: doc/BRIEF.md
# Gear Clock and System Clock Selector

This block produces the main system clock for a small controller core. A fast oscillator passes through a divider whose ratio is picked by a 2-bit gear code. The result is the gear clock. A second stage then routes either the gear clock or a quarter-rate copy of a slow oscillator onto the system clock output.

Both stages change their setting without glitches. A new gear ratio is loaded only at the end of a complete low phase of the divider, so an output phase can only be stretched and never cut short. The source switch runs a break-before-make handshake across the two asynchronous clock domains. The old source is gated off on one of its own falling edges, and the new source is then gated on at one of its own falling edges.

Software writes are single-cycle strobes sampled on the fast clock. A gear write is refused while slow mode is active, and a write of the reserved code is also refused. While a source switch is still in flight the block reports busy and refuses further select writes.

Top module: `clkgear_top`

## Requirements
- R1: Gear code 2'b00 makes gear_clk run at the fast clock divided by 4, 2'b01 divided by 2, and 2'b10 undivided.
- R2: A gear write carrying code 2'b11 is ignored, and the ratio in force before the write is kept.
- R3: After reset, gear_clk runs at the fast clock divided by 4, sys_clk follows gear_clk, and busy is low.
- R4: With select 0, sys_clk carries gear_clk. With select 1, sys_clk carries the slow clock divided by 4.
- R5: While slow_mode is high, gear writes are ignored and the ratio does not change.
- R6: A ratio change takes effect only while the divider output is low. No high or low phase of gear_clk is shorter than the smaller half period of the old and new ratios.
- R7: An accepted select write that names the other source raises busy on the next fast clock cycle. Busy stays high until the new source drives sys_clk. A select write that names the current source leaves busy low.
- R8: The two clock gates on sys_clk are never open at the same time, and no sys_clk phase is shorter than the shortest half period of the two sources involved.
- R9: A select write that arrives while busy is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_hf | input | 1 | Fast oscillator clock; the write strobes are sampled on its rising edge |
| clk_lf | input | 1 | Slow oscillator clock, asynchronous to clk_hf |
| rst_n | input | 1 | Asynchronous active-low reset |
| gear_wr | input | 1 | Gear code write strobe |
| gear_code | input | 2 | Gear code: 00 is /4, 01 is /2, 10 is /1, 11 is reserved |
| slow_mode | input | 1 | Slow-mode flag; blocks gear writes while high |
| sel_wr | input | 1 | Source select write strobe |
| sel_lf | input | 1 | Source select value: 0 for the gear clock, 1 for the slow clock divided by 4 |
| gear_clk | output | 1 | Divided fast clock |
| sys_clk | output | 1 | Main system clock |
| busy | output | 1 | High while a source switch is in progress |

## Verification
The hardest situation to reach is a ratio change that lands on the boundary between the undivided path and a divided path. There the fast clock itself is being gated in or out, and a phase could shrink to a fraction of a cycle. The stimulus steps through every ordered pair of legal codes, including /1 to /4 and back. A free-running monitor times each edge of both clock outputs against the smaller of the old and new half periods. A second demanding case is a select write issued while a switch is still in flight. The bench issues it on the cycle right after busy rises, and then checks that the source chosen by the first write is the one that finally drives sys_clk.

// File: rtl/clkgear_pkg.sv
`timescale 1ns/1ps
package clkgear_pkg;

  typedef enum logic [1:0] {
    GEAR_DIV4 = 2'b00,
    GEAR_DIV2 = 2'b01,
    GEAR_DIV1 = 2'b10,
    GEAR_RSVD = 2'b11
  } gear_e;

  // Fast-clock rising edges spent in each half period of the divider output.
  // The undivided setting uses no counting at all.
  function automatic int unsigned gear_half_cycles(gear_e code);
    case (code)
      GEAR_DIV4: return 2;
      GEAR_DIV2: return 1;
      default:   return 0;
    endcase
  endfunction

  function automatic logic gear_code_legal(logic [1:0] code);
    return code != GEAR_RSVD;
  endfunction

endpackage

// File: rtl/clkgear_ratio_ctl.sv
`timescale 1ns/1ps
module clkgear_ratio_ctl
  import clkgear_pkg::*;
(
  input  logic        clk_hf,
  input  logic        rst_n,
  input  logic        gear_wr,
  input  logic [1:0]  gear_code,
  input  logic        slow_mode,
  output gear_e       pend_code
);

  logic wr_accept;

  // A write lands only outside slow mode and only with a legal code.
  assign wr_accept = gear_wr && !slow_mode && gear_code_legal(gear_code);

  always_ff @(posedge clk_hf or negedge rst_n) begin
    if (!rst_n)
      pend_code <= GEAR_DIV4;
    else if (wr_accept)
      pend_code <= gear_e'(gear_code);
  end

endmodule

// File: rtl/clkgear_divider.sv
`timescale 1ns/1ps
module clkgear_divider
  import clkgear_pkg::*;
#(
  parameter int CNT_W = 2
) (
  input  logic  clk_hf,
  input  logic  rst_n,
  input  gear_e pend_code,
  output gear_e act_code,
  output logic  div_q,
  output logic  load_ev,
  output logic  gear_clk
);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] half_m1;
  logic             stretch;
  logic             fast_sel;
  logic             low_end;

  assign half_m1 = CNT_W'(gear_half_cycles(act_code)) - CNT_W'(1);

  // The last edge of a full low phase, or any edge on the undivided path.
  assign low_end = (act_code == GEAR_DIV1) ? 1'b1
                 : (!div_q && !stretch && (cnt == half_m1));

  assign load_ev = low_end && (pend_code != act_code);

  always_ff @(posedge clk_hf or negedge rst_n) begin
    if (!rst_n) begin
      act_code <= GEAR_DIV4;
      cnt      <= '0;
      div_q    <= 1'b0;
      stretch  <= 1'b0;
    end else if (load_ev) begin
      act_code <= pend_code;
      cnt      <= '0;
      div_q    <= 1'b0;
      stretch  <= (pend_code != GEAR_DIV1);
    end else if (act_code == GEAR_DIV1) begin
      cnt      <= '0;
      div_q    <= 1'b0;
    end else if (cnt == half_m1) begin
      cnt <= '0;
      if (stretch)
        stretch <= 1'b0;
      else
        div_q <= ~div_q;
    end else begin
      cnt <= cnt + CNT_W'(1);
    end
  end

  // The path select moves only while the fast clock is low and div_q is low.
  always_ff @(negedge clk_hf or negedge rst_n) begin
    if (!rst_n)
      fast_sel <= 1'b0;
    else
      fast_sel <= (act_code == GEAR_DIV1);
  end

  assign gear_clk = (clk_hf & fast_sel) | (div_q & ~fast_sel);

endmodule

// File: rtl/clkgear_lf_quarter.sv
`timescale 1ns/1ps
module clkgear_lf_quarter #(
  parameter int LF_DIV = 4
) (
  input  logic clk_lf,
  input  logic rst_n,
  output logic lf_q
);

  localparam int W = (LF_DIV > 2) ? $clog2(LF_DIV) : 1;

  logic [W-1:0] cnt;

  always_ff @(posedge clk_lf or negedge rst_n) begin
    if (!rst_n)
      cnt <= '0;
    else
      cnt <= cnt + W'(1);
  end

  // The counter MSB is a flop output with 50 % duty.
  assign lf_q = cnt[W-1];

endmodule

// File: rtl/clkgear_src_switch.sv
`timescale 1ns/1ps
module clkgear_src_switch #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_hf,
  input  logic rst_n,
  input  logic gear_clk,
  input  logic lf_q,
  input  logic want_lf,
  output logic en_g,
  output logic en_l,
  output logic settled,
  output logic sys_clk
);

  logic [SYNC_STAGES-1:0] g_chain;
  logic [SYNC_STAGES-1:0] l_chain;
  logic [SYNC_STAGES-1:0] g_hf;
  logic [SYNC_STAGES-1:0] l_hf;
  logic                   g_req;
  logic                   l_req;

  assign g_req = !want_lf && !en_l;
  assign l_req =  want_lf && !en_g;

  always_ff @(negedge gear_clk or negedge rst_n) begin
    if (!rst_n) g_chain <= '1;
    else        g_chain <= {g_chain[SYNC_STAGES-2:0], g_req};
  end

  always_ff @(negedge lf_q or negedge rst_n) begin
    if (!rst_n) l_chain <= '0;
    else        l_chain <= {l_chain[SYNC_STAGES-2:0], l_req};
  end

  assign en_g = g_chain[SYNC_STAGES-1];
  assign en_l = l_chain[SYNC_STAGES-1];

  // The gate states are carried back into the fast domain for the busy flag.
  always_ff @(posedge clk_hf or negedge rst_n) begin
    if (!rst_n) begin
      g_hf <= '1;
      l_hf <= '0;
    end else begin
      g_hf <= {g_hf[SYNC_STAGES-2:0], en_g};
      l_hf <= {l_hf[SYNC_STAGES-2:0], en_l};
    end
  end

  assign settled = want_lf ? ( l_hf[SYNC_STAGES-1] && !g_hf[SYNC_STAGES-1])
                           : ( g_hf[SYNC_STAGES-1] && !l_hf[SYNC_STAGES-1]);

  assign sys_clk = (gear_clk & en_g) | (lf_q & en_l);

endmodule

// File: rtl/clkgear_top.sv
`timescale 1ns/1ps
module clkgear_top
  import clkgear_pkg::*;
#(
  parameter int CNT_W       = 2,
  parameter int LF_DIV      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_hf,
  input  logic       clk_lf,
  input  logic       rst_n,
  input  logic       gear_wr,
  input  logic [1:0] gear_code,
  input  logic       slow_mode,
  input  logic       sel_wr,
  input  logic       sel_lf,
  output logic       gear_clk,
  output logic       sys_clk,
  output logic       busy
);

  gear_e pend_code;
  gear_e act_code;
  logic  div_q;
  logic  load_ev;
  logic  lf_q;
  logic  want_lf;
  logic  en_g;
  logic  en_l;
  logic  settled;

  clkgear_ratio_ctl u_ratio (
    .clk_hf    (clk_hf),
    .rst_n     (rst_n),
    .gear_wr   (gear_wr),
    .gear_code (gear_code),
    .slow_mode (slow_mode),
    .pend_code (pend_code)
  );

  clkgear_divider #(.CNT_W(CNT_W)) u_div (
    .clk_hf    (clk_hf),
    .rst_n     (rst_n),
    .pend_code (pend_code),
    .act_code  (act_code),
    .div_q     (div_q),
    .load_ev   (load_ev),
    .gear_clk  (gear_clk)
  );

  clkgear_lf_quarter #(.LF_DIV(LF_DIV)) u_lfq (
    .clk_lf (clk_lf),
    .rst_n  (rst_n),
    .lf_q   (lf_q)
  );

  always_ff @(posedge clk_hf or negedge rst_n) begin
    if (!rst_n)
      want_lf <= 1'b0;
    else if (sel_wr && !busy)
      want_lf <= sel_lf;
  end

  clkgear_src_switch #(.SYNC_STAGES(SYNC_STAGES)) u_sw (
    .clk_hf   (clk_hf),
    .rst_n    (rst_n),
    .gear_clk (gear_clk),
    .lf_q     (lf_q),
    .want_lf  (want_lf),
    .en_g     (en_g),
    .en_l     (en_l),
    .settled  (settled),
    .sys_clk  (sys_clk)
  );

  assign busy = !settled;

endmodule

// File: rtl/clkgear_checker.sv
`timescale 1ns/1ps
module clkgear_checker (
  input logic       clk_hf,
  input logic       rst_n,
  input logic       gear_wr,
  input logic [1:0] gear_code,
  input logic       slow_mode,
  input logic       sel_wr,
  input logic       sel_lf,
  input logic       busy,
  input logic [1:0] pend,
  input logic [1:0] act,
  input logic       div_q,
  input logic       load_ev,
  input logic       want_lf,
  input logic       en_g,
  input logic       en_l
);

  a_r1_pend_legal: assert property (@(posedge clk_hf) disable iff (!rst_n)
    pend != 2'b11);

  a_r2_reserved_ignored: assert property (@(posedge clk_hf) disable iff (!rst_n)
    (gear_wr && gear_code == 2'b11) |=> $stable(pend));

  a_r5_slow_lock: assert property (@(posedge clk_hf) disable iff (!rst_n)
    (gear_wr && slow_mode) |=> $stable(pend));

  a_r6_load_at_low: assert property (@(posedge clk_hf) disable iff (!rst_n)
    load_ev |-> !div_q);

  a_r6_act_moves_low: assert property (@(posedge clk_hf) disable iff (!rst_n)
    !$stable(act) |-> !div_q);

  a_r7_busy_rises: assert property (@(posedge clk_hf) disable iff (!rst_n)
    (sel_wr && !busy && (sel_lf != want_lf)) |=> busy);

  a_r8_no_overlap: assert property (@(posedge clk_hf) disable iff (!rst_n)
    !(en_g && en_l));

  a_r9_held_while_busy: assert property (@(posedge clk_hf) disable iff (!rst_n)
    (sel_wr && busy) |=> $stable(want_lf));

endmodule

bind clkgear_top clkgear_checker u_chk (
  .clk_hf    (clk_hf),
  .rst_n     (rst_n),
  .gear_wr   (gear_wr),
  .gear_code (gear_code),
  .slow_mode (slow_mode),
  .sel_wr    (sel_wr),
  .sel_lf    (sel_lf),
  .busy      (busy),
  .pend      (pend_code),
  .act       (act_code),
  .div_q     (div_q),
  .load_ev   (load_ev),
  .want_lf   (want_lf),
  .en_g      (en_g),
  .en_l      (en_l)
);

// File: tb/clkgear_top_tb.sv
`timescale 1ns/1ps
module clkgear_top_tb;

  logic       clk_hf = 1'b0;
  logic       clk_lf = 1'b0;
  logic       rst_n  = 1'b0;
  logic       gear_wr = 1'b0;
  logic [1:0] gear_code = 2'b00;
  logic       slow_mode = 1'b0;
  logic       sel_wr = 1'b0;
  logic       sel_lf = 1'b0;
  logic       gear_clk;
  logic       sys_clk;
  logic       busy;

  int  n_checks = 0;
  int  n_errors = 0;
  int  pw_viol  = 0;
  bit  done     = 1'b0;
  bit  mon_on   = 1'b0;

  // Behavioural model state: the ratio and source the requirements predict.
  int  m_code = 0;
  int  m_prev = 0;
  bit  m_lf   = 1'b0;
  realtime allowed = 2.0;
  realtime lg = 0.0;
  realtime ls = 0.0;

  always #2  clk_hf = ~clk_hf;   // 250 MHz
  always #20 clk_lf = ~clk_lf;   // slow oscillator, 40 ns

  clkgear_top u_dut (
    .clk_hf    (clk_hf),
    .clk_lf    (clk_lf),
    .rst_n     (rst_n),
    .gear_wr   (gear_wr),
    .gear_code (gear_code),
    .slow_mode (slow_mode),
    .sel_wr    (sel_wr),
    .sel_lf    (sel_lf),
    .gear_clk  (gear_clk),
    .sys_clk   (sys_clk),
    .busy      (busy)
  );

  function automatic real half_ns(int code);
    case (code)
      0: return 8.0;
      1: return 4.0;
      default: return 2.0;
    endcase
  endfunction

  function automatic real min_r(real a, real b);
    return (a < b) ? a : b;
  endfunction

  // Reference model, advanced on every fast clock edge from the port stimulus.
  always @(posedge clk_hf) begin
    if (rst_n) begin
      if (gear_wr && !slow_mode && gear_code != 2'b11) begin
        m_prev  = m_code;
        m_code  = gear_code;
        allowed = min_r(half_ns(m_prev), half_ns(m_code));
      end
      if (sel_wr && !busy) m_lf = sel_lf;
    end
  end

  // Pulse-width monitors (R6, R8).
  always @(gear_clk) begin
    if (mon_on && rst_n && ($realtime - lg < allowed - 0.01)) begin
      pw_viol++;
      $display("short gear_clk phase %0t ns at %0t", $realtime - lg, $realtime);
    end
    lg = $realtime;
  end

  always @(sys_clk) begin
    if (mon_on && rst_n && ($realtime - ls < allowed - 0.01)) begin
      pw_viol++;
      $display("short sys_clk phase %0t ns at %0t", $realtime - ls, $realtime);
    end
    ls = $realtime;
  end

  task automatic check(input bit ok, input string req, input real act, input real exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0.2f expected=%0.2f", req, act, exp);
    end
  endtask

  task automatic hf_cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_hf);
  endtask

  task automatic gear_write(input logic [1:0] code);
    @(negedge clk_hf);
    gear_wr = 1'b1; gear_code = code;
    @(negedge clk_hf);
    gear_wr = 1'b0;
    hf_cycles(40);
    allowed = half_ns(m_code);
  endtask

  task automatic measure(input bit use_sys, output real per);
    realtime t0;
    if (use_sys) begin
      @(posedge sys_clk); @(posedge sys_clk); t0 = $realtime;
      @(posedge sys_clk); per = $realtime - t0;
    end else begin
      @(posedge gear_clk); @(posedge gear_clk); t0 = $realtime;
      @(posedge gear_clk); per = $realtime - t0;
    end
    #1;
  endtask

  task automatic check_gear(input string req);
    real per;
    real exp;
    measure(1'b0, per);
    exp = 4.0 * half_ns(m_code) / 2.0 * 2.0 / 2.0 * 2.0;
    exp = 4.0 * half_ns(m_code) / 2.0;
    check((per > exp - 0.01) && (per < exp + 0.01), req, per, exp);
  endtask

  task automatic check_sys(input string req);
    real per;
    real exp;
    measure(1'b1, per);
    exp = m_lf ? 160.0 : 4.0 * half_ns(m_code) / 2.0;
    check((per > exp - 0.01) && (per < exp + 0.01), req, per, exp);
  endtask

  task automatic wait_idle(output int cyc);
    cyc = 0;
    while (busy && cyc < 4000) begin
      @(negedge clk_hf);
      cyc++;
    end
  endtask

  task automatic sel_write(input bit v);
    @(negedge clk_hf);
    sel_wr = 1'b1; sel_lf = v;
    @(negedge clk_hf);
    sel_wr = 1'b0;
  endtask

  initial begin
    int cyc;
    hf_cycles(3);
    #1 rst_n = 1'b1;
    hf_cycles(10);
    mon_on = 1'b1;
    allowed = half_ns(0);

    // R3: reset state
    check(busy == 1'b0, "R3 busy after reset", busy, 0);
    check_gear("R3 gear_clk is /4 after reset");
    check_sys("R3 sys_clk follows gear_clk after reset");

    // R1, R6: every ordered pair of legal codes
    gear_write(2'b01); check_gear("R1 code 01 gives /2");
    gear_write(2'b10); check_gear("R1 code 10 gives /1");
    gear_write(2'b00); check_gear("R1 R6 /1 to /4");
    gear_write(2'b10); check_gear("R1 R6 /4 to /1");
    gear_write(2'b01); check_gear("R1 R6 /1 to /2");
    gear_write(2'b00); check_gear("R1 R6 /2 to /4");
    check_sys("R4 sys_clk carries gear_clk with select 0");

    // R2: reserved code ignored
    gear_write(2'b11); check_gear("R2 reserved code keeps /4");

    // R5: slow mode blocks writes
    @(negedge clk_hf) slow_mode = 1'b1;
    gear_write(2'b10); check_gear("R5 write ignored in slow mode");
    @(negedge clk_hf) slow_mode = 1'b0;
    gear_write(2'b01); check_gear("R5 write accepted after slow mode");

    // R7, R9, R4: switch to the slow source
    sel_write(1'b1);
    check(busy == 1'b1, "R7 busy after select write", busy, 1);
    sel_write(1'b0);               // lands while busy: must be ignored (R9)
    wait_idle(cyc);
    check(busy == 1'b0, "R7 busy falls after switch", busy, 0);
    check_sys("R9 R4 sys_clk is slow clock /4");
    check_gear("R4 gear_clk unaffected by select");

    // Gear change while the slow source drives sys_clk
    gear_write(2'b10); check_gear("R1 /1 while slow source selected");
    check_sys("R4 sys_clk stays slow /4");

    // Back to the gear clock (R8 monitored throughout)
    sel_write(1'b0);
    check(busy == 1'b1, "R7 busy on switch back", busy, 1);
    wait_idle(cyc);
    check(busy == 1'b0, "R7 busy falls on switch back", busy, 0);
    check_sys("R8 R4 sys_clk back on gear_clk");

    // R7: same-source write leaves busy low
    sel_write(1'b0);
    check(busy == 1'b0, "R7 same-source write keeps busy low", busy, 0);

    gear_write(2'b00);
    check_sys("R6 sys_clk /4 after final change");
    check(pw_viol == 0, "R6 R8 pulse widths", pw_viol, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

endmodule